// File: doc/BRIEF.md
# Set-Clear-Toggle Register Bank

This block is a memory-mapped bank of 32-bit control words. Each word owns a 16-byte slot, and the slot has four write aliases. One alias overwrites the word. The other three OR bits in, clear bits, or flip bits. Software can therefore change a single field without a read-modify-write sequence. Every write completes in the clock cycle it is accepted. A read from any of the four aliases returns the stored word one cycle later.

The 64 KiB window holds two arrays that decode the same way. A main array of `MAIN_N` words starts at `MAIN_BASE`. An auxiliary (power-management) array of `AUX_N` words starts at `AUX_BASE`. A single read-only identification word sits at `ID_ADDR`, and it takes priority over every other decode at that address.

At reset the auxiliary words clear to zero. The main words load per-word reset values given by a parameter. Words marked in `MAIN_LOCK` also get a lock-status bit forced to one.

Top module: `scb_bank`

## Requirements
- R1: After reset, main word i holds `MAIN_RST[32*i+:32]`, and bit `LOCK_BIT` (31) is also set when `MAIN_LOCK[i]` is 1. Every auxiliary word reads zero and `rsp_valid` is low.
- R2: A full, aligned write whose address bits [3:2] equal 0 (slot offset 0x0) replaces the addressed word with `req_wdata`.
- R3: A write whose address bits [3:2] equal 1 (slot offset 0x4) ORs `req_wdata` into the word.
- R4: A write whose address bits [3:2] equal 2 (slot offset 0x8) clears each bit that is one in `req_wdata`.
- R5: A write whose address bits [3:2] equal 3 (slot offset 0xC) XORs `req_wdata` into the word.
- R6: An accepted read sets `rsp_valid` for exactly the next cycle. It returns the stored word for any of the four slot offsets, and it reflects every earlier write.
- R7: On main words marked in `MAIN_LOCK`, bit 31 reads one at all times. No write alias can clear it.
- R8: The auxiliary array at `AUX_BASE` (0x200) decodes the four aliases the same way. Its words are independent of the main array.
- R9: A read of `ID_ADDR` (0x800) returns `ID_VALUE` (0x00720010). Writes to it change nothing.
- R10: An access with `req_addr[1:0]` not zero, or with `req_be` not 4'hF, is dropped. A write changes no word, and a read returns zero.
- R11: An aligned address outside both arrays and the identification word reads zero, and writes to it change nothing.
- R12: `req_ready` is always high, and a write produces no response pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted (always high) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address in the window |
| req_be | input | 4 | Byte enables; only 4'hF is honoured |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after the read |
| rsp_rdata | output | 32 | Read data |

## Verification
A word holding a wrong value stays hidden until the next read of that word. It then appears one cycle after the read is accepted, at any of the word's four aliases. A wrong alias decode, such as an OR applied where a clear was requested, shows up on the first read after the faulty write. A decode that leaks into the wrong array shows up as an unexpected change in a word of the other array. A stuck lock bit or a writable identification word appears on the next read of that address. Random traffic spread over every region makes such faults show within a few dozen accesses.

// File: rtl/scb_pkg.sv
package scb_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned IDX_W  = 8;

  // Order follows address bits [3:2] of the slot offset.
  typedef enum logic [1:0] {
    OP_PUT  = 2'd0,
    OP_OR   = 2'd1,
    OP_ANDN = 2'd2,
    OP_XOR  = 2'd3
  } scb_op_e;

  typedef enum logic [1:0] {
    TGT_NONE = 2'd0,
    TGT_MAIN = 2'd1,
    TGT_AUX  = 2'd2,
    TGT_ID   = 2'd3
  } scb_tgt_e;

  typedef struct packed {
    scb_tgt_e         tgt;
    logic [IDX_W-1:0] idx;
    scb_op_e          op;
  } scb_dec_t;
endpackage

// File: rtl/scb_rst_sync.sv
module scb_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_out
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_n_out = sync_q;
endmodule

// File: rtl/scb_decode.sv
module scb_decode
  import scb_pkg::*;
#(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned MAIN_BASE = 'h60,
  parameter int unsigned MAIN_N    = 8,
  parameter int unsigned AUX_BASE  = 'h200,
  parameter int unsigned AUX_N     = 4,
  parameter int unsigned ID_ADDR   = 'h800
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [3:0]        be,
  output scb_dec_t          dec
);
  localparam logic [ADDR_W-1:0] MB = ADDR_W'(MAIN_BASE);
  localparam logic [ADDR_W-1:0] ME = ADDR_W'(MAIN_BASE + MAIN_N * 16);
  localparam logic [ADDR_W-1:0] AB = ADDR_W'(AUX_BASE);
  localparam logic [ADDR_W-1:0] AE = ADDR_W'(AUX_BASE + AUX_N * 16);
  localparam logic [ADDR_W-1:0] IA = ADDR_W'(ID_ADDR);

  logic [ADDR_W-1:0] main_off;
  logic [ADDR_W-1:0] aux_off;
  logic              legal;

  assign main_off = addr - MB;
  assign aux_off  = addr - AB;
  assign legal    = (addr[1:0] == 2'b00) && (be == 4'hF);

  always_comb begin
    dec.tgt = TGT_NONE;
    dec.idx = '0;
    dec.op  = scb_op_e'(addr[3:2]);
    if (legal) begin
      if (addr == IA) begin
        dec.tgt = TGT_ID;
      end else if (addr >= MB && addr < ME) begin
        dec.tgt = TGT_MAIN;
        dec.idx = main_off[IDX_W+3:4];
      end else if (addr >= AB && addr < AE) begin
        dec.tgt = TGT_AUX;
        dec.idx = aux_off[IDX_W+3:4];
      end
    end
  end
endmodule

// File: rtl/scb_regfile.sv
module scb_regfile
  import scb_pkg::*;
#(
  parameter int unsigned N        = 8,
  parameter int unsigned LOCK_BIT = 31,
  parameter logic [N*WORD_W-1:0] RST_VAL   = '0,
  parameter logic [N-1:0]        LOCK_MASK = '0,
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IW-1:0]     wr_idx,
  input  scb_op_e           wr_op,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [IW-1:0]     rd_idx,
  output logic [WORD_W-1:0] rd_data
);
  logic [N-1:0][WORD_W-1:0] words;

  for (genvar i = 0; i < N; i++) begin : g_word
    localparam logic [WORD_W-1:0] FORCE =
      LOCK_MASK[i] ? (WORD_W'(1) << LOCK_BIT) : '0;
    logic              hit;
    logic [WORD_W-1:0] q;
    logic [WORD_W-1:0] d;

    assign hit = wr_en && (wr_idx == IW'(i));

    always_comb begin
      unique case (wr_op)
        OP_PUT:  d = wr_data;
        OP_OR:   d = q | wr_data;
        OP_ANDN: d = q & ~wr_data;
        default: d = q ^ wr_data;
      endcase
      d = d | FORCE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= RST_VAL[i*WORD_W +: WORD_W] | FORCE;
      else if (hit) q <= d;
    end

    assign words[i] = q;
  end

  assign rd_data = words[rd_idx];
endmodule

// File: rtl/scb_bank.sv
module scb_bank
  import scb_pkg::*;
#(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned MAIN_N    = 8,
  parameter int unsigned AUX_N     = 4,
  parameter int unsigned MAIN_BASE = 'h60,
  parameter int unsigned AUX_BASE  = 'h200,
  parameter int unsigned ID_ADDR   = 'h800,
  parameter logic [31:0] ID_VALUE  = 32'h0072_0010,
  parameter int unsigned LOCK_BIT  = 31,
  parameter logic [MAIN_N*32-1:0] MAIN_RST = {
    32'h0000_0000, 32'h0008_201B, 32'h0001_301B, 32'h0000_1FC0,
    32'h0000_2000, 32'h0000_00FF, 32'h0060_302C, 32'h0000_2042},
  parameter logic [MAIN_N-1:0] MAIN_LOCK = 8'h7F
) (
  input  logic              clk,
  input  logic              arst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [3:0]        req_be,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata
);
  localparam int unsigned MAIN_IW = (MAIN_N > 1) ? $clog2(MAIN_N) : 1;
  localparam int unsigned AUX_IW  = (AUX_N > 1) ? $clog2(AUX_N) : 1;

  logic        rst_n_sync;
  scb_dec_t    dec;
  logic        wr_acc, rd_acc;
  logic        main_we, aux_we;
  logic [31:0] main_rd, aux_rd, rd_mux;
  logic        rsp_valid_d, rsp_valid_q;
  logic [31:0] rsp_rdata_q;

  scb_rst_sync u_rst (.clk(clk), .arst_n(arst_n), .rst_n_out(rst_n_sync));

  scb_decode #(
    .ADDR_W(ADDR_W), .MAIN_BASE(MAIN_BASE), .MAIN_N(MAIN_N),
    .AUX_BASE(AUX_BASE), .AUX_N(AUX_N), .ID_ADDR(ID_ADDR)
  ) u_dec (.addr(req_addr), .be(req_be), .dec(dec));

  assign req_ready = 1'b1;
  assign wr_acc    = req_valid && req_write;
  assign rd_acc    = req_valid && !req_write;
  assign main_we   = wr_acc && (dec.tgt == TGT_MAIN);
  assign aux_we    = wr_acc && (dec.tgt == TGT_AUX);

  scb_regfile #(
    .N(MAIN_N), .LOCK_BIT(LOCK_BIT), .RST_VAL(MAIN_RST), .LOCK_MASK(MAIN_LOCK)
  ) u_main (
    .clk(clk), .rst_n(rst_n_sync), .wr_en(main_we),
    .wr_idx(dec.idx[MAIN_IW-1:0]), .wr_op(dec.op), .wr_data(req_wdata),
    .rd_idx(dec.idx[MAIN_IW-1:0]), .rd_data(main_rd)
  );

  scb_regfile #(
    .N(AUX_N), .LOCK_BIT(LOCK_BIT), .RST_VAL('0), .LOCK_MASK('0)
  ) u_aux (
    .clk(clk), .rst_n(rst_n_sync), .wr_en(aux_we),
    .wr_idx(dec.idx[AUX_IW-1:0]), .wr_op(dec.op), .wr_data(req_wdata),
    .rd_idx(dec.idx[AUX_IW-1:0]), .rd_data(aux_rd)
  );

  always_comb begin
    unique case (dec.tgt)
      TGT_MAIN: rd_mux = main_rd;
      TGT_AUX:  rd_mux = aux_rd;
      TGT_ID:   rd_mux = ID_VALUE;
      default:  rd_mux = '0;
    endcase
    rsp_valid_d = rd_acc;
  end

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) begin
      rsp_valid_q <= 1'b0;
      rsp_rdata_q <= '0;
    end else begin
      rsp_valid_q <= rsp_valid_d;
      if (rd_acc) rsp_rdata_q <= rd_mux;
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_rdata = rsp_rdata_q;
endmodule

// File: rtl/scb_bank_chk.sv
module scb_bank_chk #(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned MAIN_BASE = 'h60,
  parameter int unsigned ID_ADDR   = 'h800,
  parameter logic [31:0] ID_VALUE  = 32'h0072_0010,
  parameter int unsigned LOCK_BIT  = 31,
  parameter logic        LOCK0     = 1'b1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic [3:0]        req_be,
  input logic              rsp_valid,
  input logic [31:0]       rsp_rdata
);
  logic good_rd;
  assign good_rd = req_valid && !req_write && (req_addr[1:0] == 2'b00) && (req_be == 4'hF);

  // R6
  rd_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> rsp_valid);

  // R12
  wr_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write) |=> !rsp_valid);

  // R9
  id_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (good_rd && req_addr == ADDR_W'(ID_ADDR)) |=> (rsp_rdata == ID_VALUE));

  // R10
  bad_rd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && (req_addr[1:0] != 2'b00 || req_be != 4'hF))
      |=> (rsp_rdata == 32'h0));

  // R7
  lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (LOCK0 && good_rd && req_addr[ADDR_W-1:4] == (ADDR_W-4)'(MAIN_BASE >> 4))
      |=> rsp_rdata[LOCK_BIT]);
endmodule

bind scb_bank scb_bank_chk #(
  .ADDR_W(ADDR_W), .MAIN_BASE(MAIN_BASE), .ID_ADDR(ID_ADDR),
  .ID_VALUE(ID_VALUE), .LOCK_BIT(LOCK_BIT), .LOCK0(MAIN_LOCK[0])
) u_chk (
  .clk(clk), .rst_n(rst_n_sync), .req_valid(req_valid), .req_write(req_write),
  .req_addr(req_addr), .req_be(req_be), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
);

// File: tb/sim_scb_bank.sv
module sim_scb_bank;
  logic        clk;
  logic        arst_n;
  logic        req_valid, req_ready, req_write;
  logic [15:0] req_addr;
  logic [3:0]  req_be;
  logic [31:0] req_wdata;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;

  int n_chk;
  int n_bad;

  localparam logic [31:0] RST_TAB [8] = '{
    32'h0000_2042, 32'h0060_302C, 32'h0000_00FF, 32'h0000_2000,
    32'h0000_1FC0, 32'h0001_301B, 32'h0008_201B, 32'h0000_0000};
  localparam logic [7:0] LOCKS = 8'h7F;

  logic [31:0] m_main [8];
  logic [31:0] m_aux  [4];

  scb_bank u0 (
    .clk(clk), .arst_n(arst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_be(req_be),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic int region(input logic [15:0] a, input logic [3:0] be);
    if (a[1:0] != 2'b00 || be != 4'hF) return 4;
    if (a == 16'h0800) return 3;
    if (a >= 16'h0060 && a < 16'h00E0) return 1;
    if (a >= 16'h0200 && a < 16'h0240) return 2;
    return 0;
  endfunction

  function automatic logic [31:0] model_read(input logic [15:0] a, input logic [3:0] be);
    int r = region(a, be);
    if (r == 1) return m_main[int'((a - 16'h0060) >> 4)];
    if (r == 2) return m_aux[int'((a - 16'h0200) >> 4)];
    if (r == 3) return 32'h0072_0010;
    return 32'h0;
  endfunction

  function automatic logic [31:0] apply_op(input logic [31:0] old, input logic [31:0] w,
                                           input logic [1:0] op);
    case (op)
      2'd0:    return w;
      2'd1:    return old | w;
      2'd2:    return old & ~w;
      default: return old ^ w;
    endcase
  endfunction

  function automatic void model_write(input logic [15:0] a, input logic [31:0] w,
                                      input logic [3:0] be);
    int r = region(a, be);
    if (r == 1) begin
      int i = int'((a - 16'h0060) >> 4);
      m_main[i] = apply_op(m_main[i], w, a[3:2]);
      if (LOCKS[i]) m_main[i][31] = 1'b1;
    end else if (r == 2) begin
      int i = int'((a - 16'h0200) >> 4);
      m_aux[i] = apply_op(m_aux[i], w, a[3:2]);
    end
  endfunction

  function automatic string tag_of(input logic [15:0] a, input logic [3:0] be);
    case (region(a, be))
      1: return "R6";
      2: return "R8";
      3: return "R9";
      4: return "R10";
      default: return "R11";
    endcase
  endfunction

  task automatic check(input logic ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%08h exp=%08h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [15:0] a, input logic [31:0] w, input logic [3:0] be);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_be = be; req_wdata = w;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    model_write(a, w, be);
    // R12: no response pulse after a write
    check(rsp_valid == 1'b0, "R12", {31'h0, rsp_valid}, 32'h0);
  endtask

  task automatic bus_read(input logic [15:0] a, input logic [3:0] be, input string tag);
    logic [31:0] exp;
    exp = model_read(a, be);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_be = be;
    @(negedge clk);
    req_valid = 1'b0;
    check(rsp_valid == 1'b1, {tag, " valid"}, {31'h0, rsp_valid}, 32'h1);
    check(rsp_rdata == exp, tag, rsp_rdata, exp);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL R6 watchdog act=hung exp=done");
    finish_run();
  end

  initial begin
    n_chk = 0; n_bad = 0;
    void'($urandom(32'd20240611));
    req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_be = 4'hF; req_wdata = '0;
    for (int i = 0; i < 8; i++) m_main[i] = RST_TAB[i] | (LOCKS[i] ? 32'h8000_0000 : 32'h0);
    for (int i = 0; i < 4; i++) m_aux[i] = 32'h0;
    arst_n = 1'b0;
    repeat (3) @(negedge clk);
    arst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    check(rsp_valid == 1'b0, "R1", {31'h0, rsp_valid}, 32'h0);
    check(req_ready == 1'b1, "R12", {31'h0, req_ready}, 32'h1);
    for (int i = 0; i < 8; i++) bus_read(16'h0060 + 16'(i * 16), 4'hF, "R1");
    for (int i = 0; i < 4; i++) bus_read(16'h0200 + 16'(i * 16), 4'hF, "R1");

    // R2: plain replace, read through another alias
    bus_write(16'h0080, 32'h1234_5678, 4'hF);
    bus_read(16'h0088, 4'hF, "R2");
    bus_write(16'h00D0, 32'h0000_0000, 4'hF);
    bus_read(16'h00DC, 4'hF, "R2");
    // R3: set
    bus_write(16'h00D4, 32'h0F0F_0001, 4'hF);
    bus_read(16'h00D0, 4'hF, "R3");
    // R4: clear
    bus_write(16'h00D8, 32'h0300_0001, 4'hF);
    bus_read(16'h00D4, 4'hF, "R4");
    // R5: toggle
    bus_write(16'h00DC, 32'hFFFF_0000, 4'hF);
    bus_read(16'h00D0, 4'hF, "R5");
    // R7: lock bit survives replace and clear
    bus_write(16'h0060, 32'h0000_0000, 4'hF);
    bus_read(16'h0060, 4'hF, "R7");
    bus_write(16'h0068, 32'hFFFF_FFFF, 4'hF);
    bus_read(16'h006C, 4'hF, "R7");
    bus_write(16'h006C, 32'h8000_0000, 4'hF);
    bus_read(16'h0064, 4'hF, "R7");
    // R8: auxiliary array, main untouched
    bus_write(16'h0230, 32'hA5A5_5A5A, 4'hF);
    bus_write(16'h023C, 32'h0000_FFFF, 4'hF);
    bus_read(16'h0230, 4'hF, "R8");
    bus_read(16'h0090, 4'hF, "R8");
    // R9: identification word
    bus_read(16'h0800, 4'hF, "R9");
    bus_write(16'h0800, 32'hDEAD_BEEF, 4'hF);
    bus_read(16'h0800, 4'hF, "R9");
    // R10: misaligned and partial accesses
    bus_write(16'h00A2, 32'hFFFF_FFFF, 4'hF);
    bus_write(16'h00A0, 32'hFFFF_FFFF, 4'h3);
    bus_read(16'h00A0, 4'hF, "R10");
    bus_read(16'h00A1, 4'hF, "R10");
    bus_read(16'h00A0, 4'h1, "R10");
    // R11: unmapped
    bus_write(16'h00E0, 32'h1111_1111, 4'hF);
    bus_read(16'h00E0, 4'hF, "R11");
    bus_read(16'h0100, 4'hF, "R11");
    bus_read(16'h005C, 4'hF, "R11");

    // Random traffic
    for (int k = 0; k < 3000; k++) begin
      logic [15:0] a;
      logic [3:0]  be;
      int          sel;
      sel = int'($urandom % 8);
      case (sel)
        0, 1, 2, 3: a = 16'h0060 + 16'(($urandom % 8) * 16) + 16'(($urandom % 4) * 4);
        4:          a = 16'h0200 + 16'(($urandom % 4) * 16) + 16'(($urandom % 4) * 4);
        5:          a = 16'h0800;
        6:          a = 16'($urandom) & 16'hFFFC;
        default:    a = 16'h0060 + 16'($urandom % 128);
      endcase
      be = (($urandom % 8) == 0) ? 4'($urandom) : 4'hF;
      if ($urandom % 2) bus_write(a, $urandom, be);
      else bus_read(a, be, tag_of(a, be));
    end

    finish_run();
  end
endmodule